// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading entries of a two-level translation structure held in memory. A request carries the virtual address and two attributes: whether the access is a write, and whether it comes from user mode. On acceptance the block also samples a base input that locates the top-level directory page. It then reads one directory entry. For a 4 KB mapping it also reads one table entry. It checks the access rights at each level it reads and updates the accessed and dirty flags in memory. It finishes with a single-cycle completion pulse that carries either a physical address with the final entry's attributes, or a 3-bit fault code.

The request side is valid/ready. `req_ready` is high only while the walker is idle, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. The memory side has one transaction outstanding at a time. The block holds `mem_req_valid`, address, write enable and write data steady until the memory raises `mem_req_ready`. A read is answered later by exactly one `mem_rsp_valid` beat. A write is complete once it is accepted and gets no response. The completion pulse cannot be stalled, so whoever consumes it must capture it in the cycle it appears.

Entries are 32 bits wide and use this layout:
- bit 0: present
- bit 1: writable
- bit 2: user-accessible
- bit 3: write-through
- bit 4: cache-disable
- bit 5: accessed
- bit 6: dirty
- bit 7: large page (meaningful in a directory entry)
- bit 8: global
- bits 11..9: free, and ignored
- bits 31..12: frame address

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `mem_req_valid` are 0. `req_ready` is 1 only while idle. A request is accepted on `req_valid && req_ready`, and `dir_base` is sampled at that edge.
- R2: The first read of every walk is at address {dir_base[31:12], vaddr[31:22], 2'b00}. A second-level read is at {directory entry[31:12], vaddr[21:12], 2'b00}.
- R3: A memory request stays asserted with a stable address and write enable until `mem_req_ready`. Each accepted request is counted once, and read data is taken only from a `mem_rsp_valid` beat.
- R4: The fault code places protection-violation in bit 0, write access in bit 1 and user mode in bit 2. A missing mapping gives bit 0 = 0.
- R5: A walk faults when an entry it reads has bit 0 clear. It also faults when a user access meets bit 2 clear, or a write meets bit 1 clear, in the directory or table entry. Supervisor writes obey bit 1 too. A directory that fails ends the walk without a table read.
- R6: A 4 KB translation gives `done_paddr` = {table entry[31:12], vaddr[11:0]}.
- R7: A directory entry with bit 7 set ends the walk after one read, with `done_paddr` = {entry[31:22], vaddr[21:0]}.
- R8: On success, a directory entry with bit 5 clear is written back with bit 5 set and all other bits unchanged. This write comes before any table write-back.
- R9: On success, the final entry is written back with bit 5 set, and with bit 6 set for a write access, whenever this changes its value.
- R10: A walk that faults issues no memory write. A walk whose entries need no change issues none either.
- R11: `done` is a one-cycle pulse. With it, `done_rw`, `done_user`, `done_global`, `done_pcd` and `done_pwt` show bits 1, 2, 8, 4 and 3 of the final entry. These outputs and `done_paddr` are 0 on a fault, and bits 11..9 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_base | input | 32 | Physical address of directory page (bits 11..0 ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory byte address (word aligned) |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_fcode | output | 3 | Fault code |
| done_paddr | output | 32 | Translated physical address |
| done_rw | output | 1 | Final entry writable bit |
| done_user | output | 1 | Final entry user bit |
| done_global | output | 1 | Final entry global bit |
| done_pcd | output | 1 | Final entry cache-disable bit |
| done_pwt | output | 1 | Final entry write-through bit |

## Verification
The properties assume that the memory answers a read with exactly one `mem_rsp_valid` beat, that this beat arrives only after the read has been accepted, and that no beat is ever produced for a write. They also assume that requests come only through the valid/ready handshake. The bench memory model replies one cycle after it accepts a read and stays silent on writes. It withholds `mem_req_ready` on a repeating pattern so that every request kind meets stalls. The driver raises `req_valid` only when `req_ready` is already high, and `dir_base` changes only between walks.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W   = 32;
  localparam int ENT_W  = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int SZ_W   = 2;
  localparam int FC_W   = 3;
  localparam int FRM_W  = VA_W - OFF_W;
  localparam int LG_W   = OFF_W + IDX_W;

  localparam int B_PRES = 0;
  localparam int B_RW   = 1;
  localparam int B_USR  = 2;
  localparam int B_WT   = 3;
  localparam int B_CD   = 4;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_BIG  = 7;
  localparam int B_GLB  = 8;

  typedef enum logic [2:0] {
    W_IDLE, W_DIR_RQ, W_DIR_WT, W_TBL_RQ, W_TBL_WT, W_DIR_WB, W_TBL_WB, W_DONE
  } walk_st_t;

  function automatic logic [ENT_W-1:0] mark_entry(input logic [ENT_W-1:0] e,
                                                  input logic set_dirty);
    logic [ENT_W-1:0] r;
    r = e;
    r[B_ACC] = 1'b1;
    if (set_dirty) r[B_DRT] = 1'b1;
    return r;
  endfunction

  function automatic logic needs_update(input logic [ENT_W-1:0] e,
                                        input logic set_dirty);
    return !e[B_ACC] || (set_dirty && !e[B_DRT]);
  endfunction
endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
(
  input  logic [B_USR:0] entry_lo,
  input  logic           is_write,
  input  logic           is_user,
  output logic           missing,
  output logic           denied
);
  always_comb begin
    missing = !entry_lo[B_PRES];
    denied  = (is_user && !entry_lo[B_USR]) || (is_write && !entry_lo[B_RW]);
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  logic [FRM_W-1:0] base_frame,
  input  logic [VA_W-1:0]  va,
  input  logic [FRM_W-1:0] dir_frame,
  input  logic [FRM_W-1:0] fin_frame,
  input  logic             big,
  output logic [VA_W-1:0]  dir_ea,
  output logic [VA_W-1:0]  tbl_ea,
  output logic [VA_W-1:0]  paddr
);
  logic [VA_W-1:0] pa_small, pa_large;

  always_comb begin
    dir_ea   = {base_frame, va[VA_W-1 -: IDX_W], {SZ_W{1'b0}}};
    tbl_ea   = {dir_frame, va[LG_W-1 -: IDX_W], {SZ_W{1'b0}}};
    pa_small = {fin_frame, va[OFF_W-1:0]};
    pa_large = {fin_frame[FRM_W-1 -: IDX_W], va[LG_W-1:0]};
    paddr    = big ? pa_large : pa_small;
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [FRM_W-1:0]  base_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic [ENT_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_rdata,
  input  logic              rsp_missing,
  input  logic              rsp_denied,
  input  logic [VA_W-1:0]   dir_ea,
  input  logic [VA_W-1:0]   tbl_ea,
  output logic              wr_o,
  output logic              usr_o,
  output logic [VA_W-1:0]   va_o,
  output logic [FRM_W-1:0]  base_o,
  output logic [FRM_W-1:0]  dir_frame_o,
  output logic [FRM_W-1:0]  fin_frame_o,
  output logic              big_o,
  output logic              done,
  output logic              done_fault,
  output logic [FC_W-1:0]   done_fcode,
  output logic              done_rw,
  output logic              done_user,
  output logic              done_global,
  output logic              done_pcd,
  output logic              done_pwt
);
  walk_st_t         st;
  logic [VA_W-1:0]  va_q;
  logic [FRM_W-1:0] base_q;
  logic [ENT_W-1:0] dir_q, tbl_q, fin;
  logic             wr_q, usr_q, big_q, fault_q, prot_q;
  logic             ok;

  assign fin         = big_q ? dir_q : tbl_q;
  assign wr_o        = wr_q;
  assign usr_o       = usr_q;
  assign va_o        = va_q;
  assign base_o      = base_q;
  assign dir_frame_o = dir_q[ENT_W-1:OFF_W];
  assign fin_frame_o = fin[ENT_W-1:OFF_W];
  assign big_o       = big_q;
  assign req_ready   = (st == W_IDLE);

  always_comb begin
    done        = (st == W_DONE);
    ok          = done && !fault_q;
    done_fault  = done && fault_q;
    done_fcode  = done_fault ? {usr_q, wr_q, prot_q} : '0;
    done_rw     = ok && fin[B_RW];
    done_user   = ok && fin[B_USR];
    done_global = ok && fin[B_GLB];
    done_pcd    = ok && fin[B_CD];
    done_pwt    = ok && fin[B_WT];
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = dir_ea;
    mem_req_wdata = '0;
    unique case (st)
      W_DIR_RQ: mem_req_valid = 1'b1;
      W_TBL_RQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = tbl_ea;
      end
      W_DIR_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = mark_entry(dir_q, big_q && wr_q);
      end
      W_TBL_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = tbl_ea;
        mem_req_wdata = mark_entry(tbl_q, wr_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      dir_q   <= '0;
      tbl_q   <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      big_q   <= 1'b0;
      fault_q <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      unique case (st)
        W_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          base_q  <= base_in;
          wr_q    <= req_write;
          usr_q   <= req_user;
          big_q   <= 1'b0;
          fault_q <= 1'b0;
          prot_q  <= 1'b0;
          st      <= W_DIR_RQ;
        end
        W_DIR_RQ: if (mem_req_ready) st <= W_DIR_WT;
        W_DIR_WT: if (mem_rsp_valid) begin
          dir_q <= mem_rsp_rdata;
          if (rsp_missing || rsp_denied) begin
            fault_q <= 1'b1;
            prot_q  <= !rsp_missing;
            st      <= W_DONE;
          end else if (mem_rsp_rdata[B_BIG]) begin
            big_q <= 1'b1;
            st    <= needs_update(mem_rsp_rdata, wr_q) ? W_DIR_WB : W_DONE;
          end else begin
            st <= W_TBL_RQ;
          end
        end
        W_TBL_RQ: if (mem_req_ready) st <= W_TBL_WT;
        W_TBL_WT: if (mem_rsp_valid) begin
          tbl_q <= mem_rsp_rdata;
          if (rsp_missing || rsp_denied) begin
            fault_q <= 1'b1;
            prot_q  <= !rsp_missing;
            st      <= W_DONE;
          end else if (!dir_q[B_ACC]) begin
            st <= W_DIR_WB;
          end else begin
            st <= needs_update(mem_rsp_rdata, wr_q) ? W_TBL_WB : W_DONE;
          end
        end
        W_DIR_WB: if (mem_req_ready) begin
          if (big_q || !needs_update(tbl_q, wr_q)) st <= W_DONE;
          else                                     st <= W_TBL_WB;
        end
        W_TBL_WB: if (mem_req_ready) st <= W_DONE;
        W_DONE:   st <= W_IDLE;
        default:  st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic [ENT_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_rdata,
  output logic              done,
  output logic              done_fault,
  output logic [FC_W-1:0]   done_fcode,
  output logic [VA_W-1:0]   done_paddr,
  output logic              done_rw,
  output logic              done_user,
  output logic              done_global,
  output logic              done_pcd,
  output logic              done_pwt
);
  logic [VA_W-1:0]  dir_ea, tbl_ea, pa, va_q;
  logic [FRM_W-1:0] base_q, dir_frame, fin_frame;
  logic             big, wr_q, usr_q, rsp_missing, rsp_denied;
  logic             unused_base_lo;

  assign unused_base_lo = ^dir_base[OFF_W-1:0];

  pt_entry_check u_check (
    .entry_lo (mem_rsp_rdata[B_USR:0]),
    .is_write (wr_q),
    .is_user  (usr_q),
    .missing  (rsp_missing),
    .denied   (rsp_denied)
  );

  pt_addr_gen u_addr (
    .base_frame (base_q),
    .va         (va_q),
    .dir_frame  (dir_frame),
    .fin_frame  (fin_frame),
    .big        (big),
    .dir_ea     (dir_ea),
    .tbl_ea     (tbl_ea),
    .paddr      (pa)
  );

  pt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_user      (req_user),
    .base_in       (dir_base[VA_W-1:OFF_W]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .rsp_missing   (rsp_missing),
    .rsp_denied    (rsp_denied),
    .dir_ea        (dir_ea),
    .tbl_ea        (tbl_ea),
    .wr_o          (wr_q),
    .usr_o         (usr_q),
    .va_o          (va_q),
    .base_o        (base_q),
    .dir_frame_o   (dir_frame),
    .fin_frame_o   (fin_frame),
    .big_o         (big),
    .done          (done),
    .done_fault    (done_fault),
    .done_fcode    (done_fcode),
    .done_rw       (done_rw),
    .done_user     (done_user),
    .done_global   (done_global),
    .done_pcd      (done_pcd),
    .done_pwt      (done_pwt)
  );

  assign done_paddr = (done && !done_fault) ? pa : '0;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OFF_W-1:0]  req_off,
  input logic              req_write,
  input logic              req_user,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [VA_W-1:0]   mem_req_addr,
  input logic              wb_acc,
  input logic              done,
  input logic              done_fault,
  input logic [FC_W-1:0]   done_fcode,
  input logic [VA_W-1:0]   done_paddr
);
  logic [OFF_W-1:0] cap_off;
  logic             cap_wr, cap_usr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_off <= '0;
      cap_wr  <= 1'b0;
      cap_usr <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_off <= req_off;
      cap_wr  <= req_write;
      cap_usr <= req_user;
    end
  end

  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[SZ_W-1:0] == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  assert_fcode_attr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_fcode[2:1] == {cap_usr, cap_wr});
  assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_paddr[OFF_W-1:0] == cap_off);
  assert_wb_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> wb_acc);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_paddr == '0);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_off       (req_vaddr[11:0]),
  .req_write     (req_write),
  .req_user      (req_user),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .wb_acc        (mem_req_wdata[5]),
  .done          (done),
  .done_fault    (done_fault),
  .done_fcode    (done_fcode),
  .done_paddr    (done_paddr)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0004_0000;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done, done_fault, done_rw, done_user, done_global, done_pcd, done_pwt;
  logic [2:0]  done_fcode;
  logic [31:0] done_paddr;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (.*);

  typedef struct {
    logic        fault;
    logic [2:0]  fcode;
    logic [31:0] paddr;
    logic [4:0]  flags;
    logic [31:0] da, nd, ta, nt;
    int          reads, writes;
  } exp_t;

  logic [31:0] mem [int];
  exp_t        scb [$];
  int          vectors = 0, miscompares = 0;
  int          rd_cnt = 0, wr_cnt = 0, cycles = 0;
  logic [31:0] first_rd = '0;
  logic [1:0]  stall = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(int'(a >> 2)) ? mem[int'(a >> 2)] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Memory responder: one-cycle read latency, ready withheld one cycle in four
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    stall <= stall + 2'd1;
    mem_req_ready <= (stall != 2'd2);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[int'(mem_req_addr >> 2)] = mem_req_wdata;
        wr_cnt++;
      end else begin
        if (rd_cnt == 0) first_rd = mem_req_addr;
        rd_cnt++;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rd(mem_req_addr);
      end
    end
  end

  function automatic exp_t model(input logic [31:0] va, input logic w, input logic u,
                                 input logic [31:0] base);
    exp_t e;
    logic [31:0] d, t, fin;
    e.fault = 0; e.fcode = 0; e.paddr = 0; e.flags = 0;
    e.da = {base[31:12], va[31:22], 2'b00};
    d = rd(e.da);
    e.nd = d; e.ta = {d[31:12], va[21:12], 2'b00}; e.nt = 0;
    e.reads = 1; e.writes = 0;
    if (!d[0] || (u && !d[2]) || (w && !d[1])) begin
      e.fault = 1; e.fcode = {u, w, d[0]};
      return e;
    end
    if (d[7]) begin
      e.nd = d | 32'h20 | (w ? 32'h40 : 32'h0);
      e.writes = (e.nd != d) ? 1 : 0;
      e.paddr = {d[31:22], va[21:0]};
      fin = d;
    end else begin
      t = rd(e.ta);
      e.nt = t; e.reads = 2;
      if (!t[0] || (u && !t[2]) || (w && !t[1])) begin
        e.fault = 1; e.fcode = {u, w, t[0]};
        return e;
      end
      e.nd = d | 32'h20;
      e.nt = t | 32'h20 | (w ? 32'h40 : 32'h0);
      e.writes = ((e.nd != d) ? 1 : 0) + ((e.nt != t) ? 1 : 0);
      e.paddr = {t[31:12], va[11:0]};
      fin = t;
    end
    e.flags = {fin[1], fin[2], fin[8], fin[4], fin[3]};
    return e;
  endfunction

  task automatic walk(input logic [31:0] va, input logic w, input logic u);
    exp_t e;
    while (!req_ready || scb.size() != 0) @(negedge clk);
    e = model(va, w, u, dir_base);
    rd_cnt = 0; wr_cnt = 0; first_rd = '0;
    scb.push_back(e);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (scb.size() == 0) chk("R11 unexpected done", 32'h1, 32'h0);
      else begin
        e = scb.pop_front();
        chk("R5 fault flag", {31'h0, done_fault}, {31'h0, e.fault});
        chk("R4 fault code", {29'h0, done_fcode}, {29'h0, e.fcode});
        chk("R6/R7 paddr", done_paddr, e.paddr);
        chk("R11 attrs", {27'h0, done_rw, done_user, done_global, done_pcd, done_pwt},
            {27'h0, e.flags});
        chk("R2 first read addr", first_rd, e.da);
        chk("R7 read count", rd_cnt, e.reads);
        chk("R10 write count", wr_cnt, e.writes);
        chk("R3 transactions", rd_cnt + wr_cnt, e.reads + e.writes);
        chk("R8 directory word", rd(e.da), e.nd);
        if (e.reads == 2) chk("R9 table word", rd(e.ta), e.nt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    mem[int'(32'h0004_0004 >> 2)] = 32'h0005_0007;   // dir 1: present, rw, user
    mem[int'(32'h0005_000C >> 2)] = 32'h1234_5007;   // tbl 3
    mem[int'(32'h0005_0010 >> 2)] = 32'h2222_2005;   // tbl 4: read-only
    mem[int'(32'h0005_0040 >> 2)] = 32'h3333_3F1F;   // tbl 16: attrs + ignored bits
    mem[int'(32'h0004_0008 >> 2)] = 32'h0006_0003;   // dir 2: supervisor only
    mem[int'(32'h0004_0010 >> 2)] = 32'h0840_0087;   // dir 4: large page
    mem[int'(32'h0004_0014 >> 2)] = 32'h0005_0005;   // dir 5: read-only dir
    mem[int'(32'h0007_0004 >> 2)] = 32'h0005_0027;   // alt dir 1, accessed set
    repeat (4) @(negedge clk);
    chk("R1 reset ready", {31'h0, req_ready}, 32'h1);
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset mem idle", {31'h0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    walk(32'h0040_3123, 0, 0);   // R6, R8: both accessed bits set
    walk(32'h0040_3123, 0, 1);   // R10: nothing to update
    walk(32'h0040_3456, 1, 1);   // R9: dirty on table entry
    walk(32'h0040_4010, 1, 0);   // R5: supervisor write to read-only
    walk(32'h0040_4010, 0, 1);
    walk(32'h0080_0000, 0, 1);   // R5: dir denies user, no table read
    walk(32'h00C0_0010, 1, 1);   // R4: missing directory entry
    walk(32'h0040_5ABC, 0, 0);   // R4: missing table entry
    walk(32'h0123_4567, 0, 1);   // R7: large page
    walk(32'h013F_FFFF, 1, 0);   // R7, R9: large page dirty
    walk(32'h0041_0ABC, 1, 1);   // R11: attrs pass, bits 11..9 ignored
    walk(32'h0140_3000, 1, 1);   // R5: write blocked at directory
    walk(32'h0140_3000, 0, 1);
    dir_base = 32'h0007_0FFF;    // R1: base sampled, low bits ignored
    walk(32'h0040_3001, 0, 0);
    while (scb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule